// File: doc/BRIEF.md
# Interrupt Request Output Controller

This block turns a small set of interrupt source flags into a single request pin for a host processor. Each source owns a status bit, raised by an event strobe, and an enable bit. The enabled, pending sources are merged into one raw request. That request reaches the pin only through a hold stage governed by a global pin-enable bit. While the pin-enable is low, the pin keeps whatever state it last had, so software can quiesce the pin without racing new events.

Software programs three registers through a simple write strobe with a register select, and reads them back through a combinational read port. The control register chooses between level signalling and a fixed-width pulse, and sets the active polarity of the pin. Status bits are write-one-to-clear. To mask the pin for a while, software first sets the pin-enable, clears the pending status bits, and then drops the pin-enable. This leaves the pin frozen in its inactive state.

Top module: `irq_pin_ctrl`

## Requirements
- R1: The raw request is the OR over all sources of (status AND enable). With pin-enable at 1, the held request takes the raw request's value at every clock edge. In level mode the pin is active exactly while the held request is 1. A source event sampled at one edge therefore shows on the pin after the following edge.
- R2: While pin-enable (control bit 0) is 0, the held request does not change. In level mode the pin keeps its state whatever the sources do. In pulse mode no new pulse starts.
- R3: Clearing status while pin-enable is 0 does not release an asserted pin. Once pin-enable returns to 1, the pin follows the current raw request one edge later.
- R4: The register select decodes as 0 = status, 1 = enable, 2 = control. A write to status clears each bit written as 1. Bits written as 0 keep their value.
- R5: When an event strobe and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R6: When control bit 1 is 1 (pulse mode), each rising edge of the held request produces one active pulse on the pin. The pulse lasts PULSE_CYC clock cycles, where PULSE_CYC = round(PULSE_NS × CLK_MHZ / 1000), which is 33 at the defaults. After the pulse the pin returns inactive even if the request stays high.
- R7: Control bit 2 selects the pin polarity: 1 is active-high, 0 is active-low. Reset clears all registers, so out of reset the pin is active-low and idles at 1.
- R8: rd_data shows the register chosen by rd_sel in the same cycle: status, enable, or the control bits zero-extended. Any other select reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set | input | NSRC | One-cycle event strobes that set status bits |
| wr_stb | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | NSRC | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | NSRC | Read data |
| irq_pin | output | 1 | Interrupt request pin |

## Verification
Two functions can land in the same cycle: a source event setting a status bit, and a software write-one-to-clear of that same bit. The bench drives the event strobe and the clear write so that both are sampled at one clock edge. It then reads the status register back and expects the bit to be set. A second overlap, a clear arriving while the pin-enable is low, is judged at the pin: the pin must stay asserted until the pin-enable returns.

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl #(
  parameter int NSRC     = 6,
  parameter int CLK_MHZ  = 200,
  parameter int PULSE_NS = 166
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_set,
  input  logic            wr_stb,
  input  logic [1:0]      wr_sel,
  input  logic [NSRC-1:0] wr_data,
  input  logic [1:0]      rd_sel,
  output logic [NSRC-1:0] rd_data,
  output logic            irq_pin
);
  localparam int PULSE_RAW = (PULSE_NS * CLK_MHZ + 500) / 1000;
  localparam int PULSE_CYC = (PULSE_RAW < 1) ? 1 : PULSE_RAW;
  localparam int CW        = $clog2(PULSE_CYC + 1);
  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_EN   = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;

  logic [NSRC-1:0] status, enable;
  logic [2:0]      ctl;
  logic            req_q;
  logic [CW-1:0]   cnt;

  wire ctl_gen  = ctl[0];
  wire ctl_mode = ctl[1];
  wire ctl_pol  = ctl[2];
  wire raw      = |(status & enable);
  wire wr_stat  = wr_stb && (wr_sel == SEL_STAT);
  wire trig     = ctl_gen && raw && !req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
      ctl    <= '0;
    end else begin
      status <= (status & ~(wr_stat ? wr_data : '0)) | evt_set;
      if (wr_stb && wr_sel == SEL_EN)  enable <= wr_data;
      if (wr_stb && wr_sel == SEL_CTL) ctl    <= wr_data[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       req_q <= 1'b0;
    else if (ctl_gen) req_q <= raw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (trig)     cnt <= CW'(PULSE_CYC);
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  wire active = ctl_mode ? (cnt != 0) : req_q;
  assign irq_pin = ctl_pol ? active : !active;

  always_comb begin
    case (rd_sel)
      SEL_STAT: rd_data = status;
      SEL_EN:   rd_data = enable;
      SEL_CTL:  rd_data = NSRC'(ctl);
      default:  rd_data = '0;
    endcase
  end

  a_r1_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_gen) |-> (req_q == $past(raw)));
  a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl_gen) |-> $stable(req_q));
  a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_stat) |-> ((status & $past(wr_data & ~evt_set)) == '0));
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_set) != '0) |-> ((status & $past(evt_set)) == $past(evt_set)));
  a_r6_pulse_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt != 0) |-> (cnt == CW'(PULSE_CYC)));
  a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && cnt == 0) |-> (irq_pin == !ctl_pol));
endmodule

// File: tb/irq_pin_ctrl_bench.sv
module irq_pin_ctrl_bench;
  localparam int N = 6;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] evt_set = '0, wr_data = '0;
  logic wr_stb = 0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [N-1:0] rd_data;
  logic irq_pin;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  irq_pin_ctrl u_irq_pin_ctrl (.clk(clk), .rst_n(rst_n), .evt_set(evt_set), .wr_stb(wr_stb),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq_pin(irq_pin));

  // {enable, event, expected active-high pin}
  localparam logic [12:0] VEC [6] = '{
    {6'h3F, 6'h01, 1'b1}, {6'h00, 6'h3F, 1'b0}, {6'h20, 6'h20, 1'b1},
    {6'h15, 6'h2A, 1'b0}, {6'h2A, 6'h0A, 1'b1}, {6'h01, 6'h00, 1'b0}};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk); wr_stb = 1; wr_sel = a; wr_data = d;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic ev(input logic [N-1:0] m);
    @(negedge clk); evt_set = m;
    @(negedge clk); evt_set = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    rd_sel = a; #0.5; d = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [N-1:0] d;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R7 reset pin idle high", irq_pin, 1);
    rd(2'd0, d); check("R8 reset status", d, 0);
    rd(2'd2, d); check("R8 reset control", d, 0);

    wr(2'd2, 6'h05);  // gen=1, level, active-high
    @(negedge clk);
    foreach (VEC[i]) begin
      wr(2'd0, 6'h3F);
      wr(2'd1, VEC[i][12:7]);
      ev(VEC[i][6:1]);
      @(negedge clk);
      check($sformatf("R1 vector %0d", i), irq_pin, VEC[i][0]);
    end

    // R4: write 0 keeps, write 1 clears
    wr(2'd0, 6'h3F); wr(2'd1, 6'h01); ev(6'h01);
    wr(2'd0, 6'h3E);
    rd(2'd0, d); check("R4 write zero keeps", d, 1);
    wr(2'd0, 6'h01);
    rd(2'd0, d); check("R4 write one clears", d, 0);
    @(negedge clk);
    check("R1 pin drops after clear", irq_pin, 0);

    // R5: set and clear same cycle
    @(negedge clk); evt_set = 6'h04; wr_stb = 1; wr_sel = 2'd0; wr_data = 6'h04;
    @(negedge clk); evt_set = '0; wr_stb = 0;
    rd(2'd0, d); check("R5 set wins over clear", d, 6'h04);
    wr(2'd0, 6'h3F);

    // R2/R3: freeze asserted, clear while frozen
    ev(6'h01); @(negedge clk);
    check("R1 asserted before freeze", irq_pin, 1);
    wr(2'd2, 6'h04);
    wr(2'd0, 6'h3F); @(negedge clk);
    check("R3 pin held after clear with gen off", irq_pin, 1);
    wr(2'd2, 6'h05); @(negedge clk);
    check("R3 pin follows once gen back", irq_pin, 0);

    // temporary-disable procedure: frozen inactive ignores events
    wr(2'd2, 6'h04);
    ev(6'h01); @(negedge clk); @(negedge clk);
    check("R2 frozen inactive ignores event", irq_pin, 0);
    wr(2'd2, 6'h05); @(negedge clk);
    check("R3 pending event shows after reenable", irq_pin, 1);
    wr(2'd0, 6'h3F); @(negedge clk);

    // R7 active-low polarity
    wr(2'd2, 6'h01); ev(6'h01); @(negedge clk);
    check("R7 active-low asserted", irq_pin, 0);
    wr(2'd0, 6'h3F); @(negedge clk);
    check("R7 active-low idle", irq_pin, 1);

    // R6 pulse width
    wr(2'd2, 6'h07);
    ev(6'h01);
    cnt = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (irq_pin) cnt++;
    end
    check("R6 pulse width", cnt, 33);
    check("R6 pin inactive after pulse", irq_pin, 0);
    rd(2'd0, d); check("R6 status still pending", d, 1);

    // R2 in pulse mode: no pulse while gen off
    wr(2'd0, 6'h3F); @(negedge clk);
    wr(2'd2, 6'h06);
    ev(6'h01);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (irq_pin) cnt++;
    end
    check("R2 no pulse while gen off", cnt, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule